// File: doc/BRIEF.md
# Distributed DRAM Refresh Scheduler

This block paces refresh for a DRAM array so that every row is refreshed once per retention window, with the refresh commands spaced evenly over the window instead of grouped into bursts. A free-running down-counter expires once per interval. Each expiry asks for one all-bank refresh command, and that command covers a fixed group of consecutive rows. While a command runs, the block holds a busy output for a fixed number of cycles. During that time it refuses new accesses from the access path.

The access path signals an in-flight access. A refresh that falls due during an access waits until the first idle cycle. The interval timer keeps running from its nominal expiry, so a late command does not shift the commands that follow. The block holds at most one waiting refresh. A second expiry while one is still waiting sets a sticky error flag. A sweep timer measures the time from one pass over the whole array to the next. If a pass takes longer than the retention limit, a second sticky flag is set.

The row count, rows per command, interval, busy time and sweep limit are parameters in clock cycles. The default values target 65536 rows, 8 rows per command, a 16.9 µs interval, a 350 ns busy time and a 138.6 ms window at 200 MHz. With these values the overhead is about 2.07 %.

Top module: `rfs_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `ref_busy`, `ref_issue`, `sweep_done`, `pend_ovf` and `ret_viol` are 0 and `ref_row` is 0.
- R2: With `acc_inflight` held low, consecutive `ref_issue` pulses are exactly `INTERVAL_CYC` cycles apart.
- R3: Each command holds `ref_busy` high for exactly `BUSY_CYC` consecutive cycles. The first of these cycles is the cycle in which `ref_issue` pulses. A command is issued only when `ref_busy` was low in the cycle before.
- R4: Over one full sweep with no access traffic, the number of busy cycles divided by the elapsed cycles equals `BUSY_CYC / INTERVAL_CYC`.
- R5: `ref_row` holds the first row of the command in progress. It is 0 for the first command after reset, rises by `ROWS_PER_CMD` with each command, and goes from `ROWS - ROWS_PER_CMD` back to 0.
- R6: `sweep_done` is a one-cycle pulse that coincides with the `ref_issue` of the command whose `ref_row` is `ROWS - ROWS_PER_CMD`. It is low at all other times.
- R7: `acc_gnt` is low whenever `ref_busy` is high or a refresh is due or waiting. Otherwise it follows `acc_req`.
- R8: A refresh is never issued in a cycle after `acc_inflight` was high. A deferred refresh is issued on the first cycle after `acc_inflight` falls. The next command still comes `INTERVAL_CYC` cycles after the nominal slot of the deferred one.
- R9: An interval expiry while a refresh is already waiting sets `pend_ovf`. The flag stays set until reset.
- R10: If a sweep does not finish within `SWEEP_LIMIT_CYC` cycles, `ret_viol` is set. The flag stays set until reset. A sweep without deferrals leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | Access path requests a new access |
| acc_inflight | input | 1 | An access is in progress and must not be interrupted |
| acc_gnt | output | 1 | Access request granted this cycle |
| ref_busy | output | 1 | Refresh command in progress; array unavailable |
| ref_issue | output | 1 | One-cycle pulse at the start of each refresh command |
| ref_row | output | ROW_W | First row covered by the current command |
| sweep_done | output | 1 | One-cycle pulse when the last row group is refreshed |
| pend_ovf | output | 1 | Sticky flag: refresh expiry lost while one was waiting |
| ret_viol | output | 1 | Sticky flag: a sweep exceeded the retention limit |

## Verification
A wrong interval count shows up as an error in `ref_issue` spacing at the next command. A wrong busy count shows as a busy run of the wrong length within `BUSY_CYC` cycles. A row pointer that is off or fails to wrap gives a wrong `ref_row` on the very next command. The same fault also moves or removes `sweep_done` within one sweep. A fault in the waiting-refresh logic shows within one interval of a held access: the command issues while the access is still running, never issues, or `pend_ovf` changes in the wrong cycle. Faults in the sweep timer only show after a full sweep, which is why the tests deliberately push one sweep past its limit.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   // Counter width able to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
   parameter int unsigned INTERVAL_CYC = 3383
) (
   input  logic clk,
   input  logic rst,
   output logic expire
);
   localparam int unsigned CW = rfs_pkg::idx_width(INTERVAL_CYC);
   localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);

   logic [CW-1:0] cnt_q;

   assign expire = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= RELOAD;
      else if (expire) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - CW'(1);
   end
endmodule

// File: rtl/rfs_arbiter.sv
module rfs_arbiter (
   input  logic clk,
   input  logic rst,
   input  logic expire,
   input  logic acc_req,
   input  logic acc_inflight,
   input  logic busy,
   output logic issue_now,
   output logic acc_gnt,
   output logic pend_ovf
);
   logic pending_q;
   logic want;

   assign want      = expire | pending_q;
   assign issue_now = want & ~acc_inflight & ~busy;
   assign acc_gnt   = acc_req & ~busy & ~want;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         pend_ovf  <= 1'b0;
      end else if (issue_now) begin
         // one request consumed; a simultaneous second one stays waiting
         pending_q <= pending_q & expire;
      end else if (expire) begin
         if (pending_q) pend_ovf <= 1'b1;
         pending_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rfs_busy_timer.sv
module rfs_busy_timer #(
   parameter int unsigned BUSY_CYC = 70
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = rfs_pkg::idx_width(BUSY_CYC + 1);

   logic [CW-1:0] cnt_q;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst)        cnt_q <= '0;
      else if (start) cnt_q <= CW'(BUSY_CYC);
      else if (busy)  cnt_q <= cnt_q - CW'(1);
   end
endmodule

// File: rtl/rfs_row_counter.sv
module rfs_row_counter #(
   parameter  int unsigned ROWS         = 65536,
   parameter  int unsigned ROWS_PER_CMD = 8,
   localparam int unsigned ROW_W        = rfs_pkg::idx_width(ROWS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             wrap_now,
   output logic [ROW_W-1:0] ref_row
);
   localparam int unsigned CMDS = ROWS / ROWS_PER_CMD;
   localparam int unsigned GW   = rfs_pkg::idx_width(CMDS);
   localparam logic [GW-1:0] LAST_GRP = GW'(CMDS - 1);

   logic [GW-1:0]    grp_q;
   logic [ROW_W-1:0] row_of_grp;

   assign wrap_now = start & (grp_q == LAST_GRP);

   generate
      if (ROWS_PER_CMD == 1) begin : g_single
         assign row_of_grp = ROW_W'(grp_q);
      end else if (rfs_pkg::is_pow2(ROWS_PER_CMD)) begin : g_shift
         localparam int unsigned OFS_W = $clog2(ROWS_PER_CMD);
         assign row_of_grp = ROW_W'({grp_q, {OFS_W{1'b0}}});
      end else begin : g_mult
         assign row_of_grp = ROW_W'(grp_q) * ROW_W'(ROWS_PER_CMD);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         grp_q   <= '0;
         ref_row <= '0;
      end else if (start) begin
         ref_row <= row_of_grp;
         grp_q   <= wrap_now ? '0 : grp_q + GW'(1);
      end
   end
endmodule

// File: rtl/rfs_sweep_monitor.sv
module rfs_sweep_monitor #(
   parameter int unsigned SWEEP_LIMIT_CYC = 27720000
) (
   input  logic clk,
   input  logic rst,
   input  logic wrap_now,
   output logic ret_viol
);
   localparam int unsigned CW = rfs_pkg::idx_width(SWEEP_LIMIT_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(SWEEP_LIMIT_CYC);

   logic [CW-1:0] age_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         age_q    <= '0;
         ret_viol <= 1'b0;
      end else begin
         if (wrap_now)            age_q <= '0;
         else if (age_q != LIMIT) age_q <= age_q + CW'(1);
         if (!wrap_now && age_q == LIMIT) ret_viol <= 1'b1;
      end
   end
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched #(
   parameter  int unsigned ROWS            = 65536,
   parameter  int unsigned ROWS_PER_CMD    = 8,
   parameter  int unsigned INTERVAL_CYC    = 3383,
   parameter  int unsigned BUSY_CYC        = 70,
   parameter  int unsigned SWEEP_LIMIT_CYC = 27720000,
   localparam int unsigned ROW_W           = rfs_pkg::idx_width(ROWS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             acc_req,
   input  logic             acc_inflight,
   output logic             acc_gnt,
   output logic             ref_busy,
   output logic             ref_issue,
   output logic [ROW_W-1:0] ref_row,
   output logic             sweep_done,
   output logic             pend_ovf,
   output logic             ret_viol
);
   localparam int unsigned CMDS = ROWS / ROWS_PER_CMD;

   generate
      if (ROWS_PER_CMD == 0 || (ROWS % ROWS_PER_CMD) != 0) begin : g_bad_group
         $error("ROWS must be a nonzero multiple of ROWS_PER_CMD");
      end
      if (CMDS < 2) begin : g_bad_cmds
         $error("a sweep needs at least two commands");
      end
      if (BUSY_CYC == 0 || BUSY_CYC >= INTERVAL_CYC) begin : g_bad_busy
         $error("BUSY_CYC must be nonzero and shorter than INTERVAL_CYC");
      end
      if (CMDS * INTERVAL_CYC > SWEEP_LIMIT_CYC) begin : g_bad_limit
         $error("nominal sweep time exceeds SWEEP_LIMIT_CYC");
      end
   endgenerate

   logic expire;
   logic issue_now;
   logic wrap_now;

   rfs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
      .clk(clk), .rst(rst), .expire(expire)
   );

   rfs_arbiter u_arb (
      .clk(clk), .rst(rst), .expire(expire), .acc_req(acc_req),
      .acc_inflight(acc_inflight), .busy(ref_busy), .issue_now(issue_now),
      .acc_gnt(acc_gnt), .pend_ovf(pend_ovf)
   );

   rfs_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst(rst), .start(issue_now), .busy(ref_busy)
   );

   rfs_row_counter #(.ROWS(ROWS), .ROWS_PER_CMD(ROWS_PER_CMD)) u_rows (
      .clk(clk), .rst(rst), .start(issue_now), .wrap_now(wrap_now),
      .ref_row(ref_row)
   );

   rfs_sweep_monitor #(.SWEEP_LIMIT_CYC(SWEEP_LIMIT_CYC)) u_sweep (
      .clk(clk), .rst(rst), .wrap_now(wrap_now), .ret_viol(ret_viol)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_issue  <= 1'b0;
         sweep_done <= 1'b0;
      end else begin
         ref_issue  <= issue_now;
         sweep_done <= wrap_now;
      end
   end
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
   parameter  int unsigned ROWS         = 65536,
   parameter  int unsigned ROWS_PER_CMD = 8,
   parameter  int unsigned BUSY_CYC     = 70,
   localparam int unsigned ROW_W        = rfs_pkg::idx_width(ROWS)
) (
   input logic             clk,
   input logic             rst,
   input logic             acc_inflight,
   input logic             acc_gnt,
   input logic             ref_busy,
   input logic             ref_issue,
   input logic [ROW_W-1:0] ref_row,
   input logic             sweep_done,
   input logic             pend_ovf,
   input logic             ret_viol
);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - ROWS_PER_CMD);

   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (rst)           run_q <= 0;
      else if (ref_busy) run_q <= run_q + 1;
      else               run_q <= 0;
   end

   AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (rst)
      ref_busy |-> !acc_gnt);                                          // R7
   AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_busy) |-> ref_issue);                                  // R3
   AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
      ref_issue |-> !$past(ref_busy));                                 // R3
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
      $fell(ref_busy) |-> (run_q == BUSY_CYC));                        // R3
   AST_NO_ISSUE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
      ref_issue |-> !$past(acc_inflight));                             // R8
   AST_SWEEP_DONE: assert property (@(posedge clk) disable iff (rst)
      sweep_done |-> (ref_issue && ref_row == LAST_ROW));              // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      pend_ovf |=> pend_ovf);                                          // R9
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
      ret_viol |=> ret_viol);                                          // R10
endmodule

bind rfs_sched rfs_sched_chk #(
   .ROWS(ROWS), .ROWS_PER_CMD(ROWS_PER_CMD), .BUSY_CYC(BUSY_CYC)
) u_chk (
   .clk(clk), .rst(rst), .acc_inflight(acc_inflight), .acc_gnt(acc_gnt),
   .ref_busy(ref_busy), .ref_issue(ref_issue), .ref_row(ref_row),
   .sweep_done(sweep_done), .pend_ovf(pend_ovf), .ret_viol(ret_viol)
);

// File: tb/rfs_sched_tb.sv
`timescale 1ns/1ps
module rfs_sched_tb_top;
   localparam int unsigned ROWS  = 64;
   localparam int unsigned RPC   = 8;
   localparam int unsigned IVL   = 40;
   localparam int unsigned BUSY  = 8;
   localparam int unsigned LIMIT = 340;
   localparam int unsigned CMDS  = ROWS / RPC;
   localparam int unsigned ROW_W = $clog2(ROWS);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic acc_req = 1'b0;
   logic acc_inflight = 1'b0;
   logic acc_gnt, ref_busy, ref_issue, sweep_done, pend_ovf, ret_viol;
   logic [ROW_W-1:0] ref_row;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rfs_sched #(
      .ROWS(ROWS), .ROWS_PER_CMD(RPC), .INTERVAL_CYC(IVL),
      .BUSY_CYC(BUSY), .SWEEP_LIMIT_CYC(LIMIT)
   ) dut_i (
      .clk(clk), .rst(rst), .acc_req(acc_req), .acc_inflight(acc_inflight),
      .acc_gnt(acc_gnt), .ref_busy(ref_busy), .ref_issue(ref_issue),
      .ref_row(ref_row), .sweep_done(sweep_done), .pend_ovf(pend_ovf),
      .ret_viol(ret_viol)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic step_to(input int target);
      while (cyc < target) step();
   endtask

   task automatic wait_issue(output int c);
      step();
      while (!ref_issue) step();
      c = cyc;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      acc_req = 1'b0;
      acc_inflight = 1'b0;
      repeat (3) step();
      rst = 1'b0;
      step();
   endtask

   // R1: quiet outputs during and right after reset
   task automatic t_reset();
      rst = 1'b1;
      repeat (3) step();
      check(!ref_busy && !ref_issue && !sweep_done, "R1 strobes in reset",
            {ref_busy, ref_issue, sweep_done}, 0);
      check(!pend_ovf && !ret_viol && ref_row == 0, "R1 flags/row in reset",
            {pend_ovf, ret_viol, ref_row}, 0);
      rst = 1'b0;
      step();
      check(!ref_busy && !ref_issue && !pend_ovf && !ret_viol && ref_row == 0,
            "R1 first cycle after reset",
            {ref_busy, ref_issue, pend_ovf, ret_viol, ref_row}, 0);
   endtask

   // R2 R3 R4 R5 R6 over one sweep plus one command
   task automatic t_periodic();
      int c_prev, c0, bsum, bint, exp_row;
      wait_issue(c_prev);
      c0 = c_prev;
      check(ref_row == 0, "R5 first row after reset", ref_row, 0);
      exp_row = 0;
      bsum = 0;
      for (int k = 0; k < CMDS; k++) begin
         bint = 0;
         while (1) begin
            if (ref_busy) bint++;
            step();
            if (ref_issue) break;
            check(!sweep_done, "R6 no pulse between commands", sweep_done, 0);
         end
         check(bint == BUSY, "R3 busy cycles per command", bint, BUSY);
         check(cyc - c_prev == IVL, "R2 command spacing", cyc - c_prev, IVL);
         bsum += bint;
         c_prev = cyc;
         exp_row = (exp_row + RPC) % ROWS;
         check(ref_row == exp_row, "R5 row step", ref_row, exp_row);
         check(sweep_done == (exp_row == ROWS - RPC), "R6 pulse on last group",
               sweep_done, exp_row == ROWS - RPC);
      end
      check(bsum * IVL == BUSY * (c_prev - c0), "R4 busy fraction",
            bsum * IVL, BUSY * (c_prev - c0));
      check(!ret_viol && !pend_ovf, "R10 clean sweep leaves flags low",
            {ret_viol, pend_ovf}, 0);
   endtask

   // R7: grant blocked while busy, passed through when idle
   task automatic t_grant();
      int c;
      wait_issue(c);
      acc_req = 1'b1;
      #0.5;
      check(!acc_gnt, "R7 no grant while busy", acc_gnt, 0);
      step_to(c + BUSY);
      check(!ref_busy && acc_gnt, "R7 grant when idle", {ref_busy, acc_gnt}, 1);
      acc_req = 1'b0;
      #0.5;
      check(!acc_gnt, "R7 grant follows request", acc_gnt, 0);
   endtask

   // R8: deferral behind an in-flight access, schedule kept
   task automatic t_defer();
      int n, c;
      wait_issue(n);
      step_to(n + IVL - 2);
      acc_inflight = 1'b1;
      step_to(n + IVL + 1);
      acc_req = 1'b1;
      #0.5;
      check(!ref_busy && !ref_issue, "R8 no refresh during access",
            {ref_busy, ref_issue}, 0);
      check(!acc_gnt, "R7 no grant while refresh waits", acc_gnt, 0);
      acc_req = 1'b0;
      step_to(n + IVL + 3);
      acc_inflight = 1'b0;
      wait_issue(c);
      check(c == n + IVL + 4, "R8 deferred issue on first idle cycle", c, n + IVL + 4);
      wait_issue(c);
      check(c == n + 2 * IVL, "R8 next command on nominal slot", c, n + 2 * IVL);
   endtask

   // R9: second expiry while one waits
   task automatic t_overflow();
      int n;
      wait_issue(n);
      step_to(n + IVL - 2);
      acc_inflight = 1'b1;
      step_to(n + 2 * IVL - 1);
      check(!pend_ovf, "R9 one waiting refresh is no error", pend_ovf, 0);
      step_to(n + 2 * IVL + 1);
      check(pend_ovf, "R9 flag on second expiry", pend_ovf, 1);
      step_to(n + 2 * IVL + 5);
      acc_inflight = 1'b0;
      step_to(n + 3 * IVL + 10);
      check(pend_ovf, "R9 flag sticky", pend_ovf, 1);
      do_reset();
      check(!pend_ovf, "R1 reset clears overflow", pend_ovf, 0);
   endtask

   // R10: last command of a sweep pushed past the limit
   task automatic t_retention();
      int n;
      for (int k = 0; k < CMDS - 1; k++) wait_issue(n);
      check(!ret_viol, "R10 no violation before limit", ret_viol, 0);
      step_to(n + IVL - 2);
      acc_inflight = 1'b1;
      step_to(n + IVL + 30);
      acc_inflight = 1'b0;
      step_to(n + IVL + 40);
      check(ret_viol, "R10 late sweep flagged", ret_viol, 1);
      check(!pend_ovf, "R9 single late command no overflow", pend_ovf, 0);
      step_to(n + 3 * IVL);
      check(ret_viol, "R10 flag sticky", ret_viol, 1);
      do_reset();
      check(!ret_viol, "R1 reset clears violation", ret_viol, 0);
   endtask

   initial begin
      t_reset();
      t_periodic();
      t_grant();
      t_defer();
      t_overflow();
      t_retention();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule